// File: doc/BRIEF.md
# Staged Interrupt Flag Controller

This block holds the interrupt flags of a power-management controller and lets a host clear them in two phases. Sixteen flag positions are grouped as a low byte and a high byte. Each flag is set by a one-cycle pulse on its event input and stays set until the host clears it. A level interrupt output is high while any flag is set.

To clear flags, the host first writes a pair of clear-mask bytes over a simple synchronous register bus. Writing the mask alone clears nothing. The masked flags are cleared only after the host sets the trigger bit in a separate command register. The unit also holds a read-only over-current cause register, which records which circuit raised the over-current flag and is emptied together with that flag. A 4-bit operating-mode register is loaded by the system and is forced to zero when the AC-missing condition is entered.

The bus writes on the clock edge where `bus_wr` is high. A read registers `bus_rdata` on the clock edge where `bus_rd` is high, so the data is valid one cycle after the request.

Top module: `irq_stage_ctrl`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets flag i at the next clock edge, and the flag stays set until it is cleared. Flags 7..0 read at address 0x00 and flags 15..8 at address 0x01. Read data appears on `bus_rdata` one cycle after the cycle in which `bus_rd` is high.
- R2: Low bit 1 (flag 1) and high bit 5 (flag 13) are reserved. Their events are ignored, they always read 0, and mask bits written there never clear any flag.
- R3: A write to mask address 0x02 (low byte) or 0x03 (high byte) on its own leaves every flag unchanged.
- R4: A write to address 0x04 with data bit 5 = 1 clears the flags selected by the staged mask. The cleared flags read 0 two cycles after that write. The mask then returns to 0 by itself. The mask addresses and the command address always read 0.
- R5: If an event pulse arrives in the same cycle as a triggered clear of that flag, the flag stays set.
- R6: A trigger issued while the mask is all zeros changes no flag.
- R7: `irq_out` is high one cycle after any flag is set. It goes low in the cycle after the last flag is cleared.
- R8: The over-current cause register reads at address 0x05. Bit 4 is divider over-current, set by `oc_div_evt`. Bit 0 is main-regulator over-current, set by `oc_main_evt`. The other bits read 0. Either cause input also sets the over-current flag (low bit 3). Both cause bits clear when a triggered clear actually clears that flag.
- R9: The operating-mode register reads at address 0x06 with the upper nibble 0. It is loaded from `mode_val` when `mode_wr` is high. The encodings are: 0000 AC missing, 0001 basic protocol, 0010 extended protocol, 0011 proprietary protocol, 1000 transmit, and 1001 transmit stopped on foreign object or conflict.
- R10: An AC-missing event (`evt_pulse[10]`, high bit 2) forces the operating mode to 0000. This takes priority over a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_pulse | input | 16 | Per-flag event pulses |
| oc_div_evt | input | 1 | Divider over-current event |
| oc_main_evt | input | 1 | Main-regulator over-current event |
| mode_wr | input | 1 | Operating-mode load strobe |
| mode_val | input | 4 | Operating-mode load value |
| irq_out | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is an event pulse that lands in exactly the cycle in which a staged clear takes effect. That cycle is one cycle after the command write, and nothing visible at the ports marks it. The bench therefore drives the event on the falling edge right after the command write is accepted, and then reads the flag back. The over-current cause clear is checked the same way. The bench also checks that a trigger whose mask misses the over-current flag leaves the cause bits untouched, and it sweeps every flag position through set, staged-mask and triggered-clear phases.

// File: rtl/irq_stage_pkg.sv
package irq_stage_pkg;
  localparam int NF       = 16;
  localparam int BW       = 8;
  localparam int MW       = 4;
  localparam logic [NF-1:0] VALID_MASK = 16'hDFFD;
  localparam int OC_IDX   = 3;
  localparam int ACM_IDX  = 10;
  localparam int TRIG_BIT = 5;
  localparam int CAUSE_DIV_BIT  = 4;
  localparam int CAUSE_MAIN_BIT = 0;
  localparam logic [7:0] A_FLAG_LO = 8'h00;
  localparam logic [7:0] A_FLAG_HI = 8'h01;
  localparam logic [7:0] A_MASK_LO = 8'h02;
  localparam logic [7:0] A_MASK_HI = 8'h03;
  localparam logic [7:0] A_CMD     = 8'h04;
  localparam logic [7:0] A_CAUSE   = 8'h05;
  localparam logic [7:0] A_MODE    = 8'h06;
endpackage

// File: rtl/irq_clear_stage.sv
module irq_clear_stage
  import irq_stage_pkg::*;
#(
  parameter int NBYTES = NF / BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBYTES-1:0] mask_wr,
  input  logic [BW-1:0]     wdata,
  input  logic              cmd_wr,
  output logic              go,
  output logic [NF-1:0]     mask
);
  localparam int LAST = NBYTES - 1;

  always_ff @(posedge clk) begin
    if (rst) go <= 1'b0;
    else     go <= cmd_wr & wdata[TRIG_BIT];
  end

  for (genvar b = 0; b <= LAST; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        mask[b*BW +: BW] <= '0;
      else if (mask_wr[b])
        mask[b*BW +: BW] <= wdata & VALID_MASK[b*BW +: BW];
      else if (go)
        mask[b*BW +: BW] <= '0;
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_stage_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] evt,
  input  logic          oc_div,
  input  logic          oc_main,
  input  logic          go,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] flags,
  output logic [1:0]    cause,
  output logic          irq
);
  logic [NF-1:0] evt_all;
  logic [NF-1:0] clr;
  logic          oc_cleared;

  always_comb begin
    evt_all = evt;
    evt_all[OC_IDX] = evt[OC_IDX] | oc_div | oc_main;
    clr = go ? mask : '0;
    oc_cleared = clr[OC_IDX] & ~evt_all[OC_IDX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      cause <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= ((flags & ~clr) | evt_all) & VALID_MASK;
      cause <= (oc_cleared ? 2'b00 : cause) | {oc_div, oc_main};
      irq   <= |flags;
    end
  end
endmodule

// File: rtl/irq_stage_ctrl.sv
module irq_stage_ctrl
  import irq_stage_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NF-1:0] evt_pulse,
  input  logic          oc_div_evt,
  input  logic          oc_main_evt,
  input  logic          mode_wr,
  input  logic [MW-1:0] mode_val,
  output logic          irq_out
);
  localparam int NBYTES = NF / BW;

  logic [NBYTES-1:0] mask_wr;
  logic              cmd_wr;
  logic              go_q;
  logic [NF-1:0]     mask_q;
  logic [NF-1:0]     flags_q;
  logic [1:0]        cause_q;
  logic [MW-1:0]     mode_q;
  logic [DW-1:0]     rd_mux;

  always_comb begin
    mask_wr[0] = bus_wr && (bus_addr == AW'(A_MASK_LO));
    mask_wr[1] = bus_wr && (bus_addr == AW'(A_MASK_HI));
    cmd_wr     = bus_wr && (bus_addr == AW'(A_CMD));
  end

  irq_clear_stage #(.NBYTES(NBYTES)) u_stage (
    .clk    (clk),
    .rst    (rst),
    .mask_wr(mask_wr),
    .wdata  (bus_wdata),
    .cmd_wr (cmd_wr),
    .go     (go_q),
    .mask   (mask_q)
  );

  irq_flag_bank u_bank (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt_pulse),
    .oc_div (oc_div_evt),
    .oc_main(oc_main_evt),
    .go     (go_q),
    .mask   (mask_q),
    .flags  (flags_q),
    .cause  (cause_q),
    .irq    (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst)                     mode_q <= '0;
    else if (evt_pulse[ACM_IDX]) mode_q <= '0;
    else if (mode_wr)            mode_q <= mode_val;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(A_FLAG_LO): rd_mux = flags_q[BW-1:0];
      AW'(A_FLAG_HI): rd_mux = flags_q[NF-1:BW];
      AW'(A_CAUSE): begin
        rd_mux[CAUSE_DIV_BIT]  = cause_q[1];
        rd_mux[CAUSE_MAIN_BIT] = cause_q[0];
      end
      AW'(A_MODE):    rd_mux[MW-1:0] = mode_q;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_stage_ctrl_chk.sv
module irq_stage_ctrl_chk
  import irq_stage_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [NF-1:0] evt_pulse,
  input logic          go_q,
  input logic [NF-1:0] mask_q,
  input logic [NF-1:0] flags_q,
  input logic [1:0]    cause_q,
  input logic [3:0]    mode_q,
  input logic          irq_out,
  input logic [1:0]    mask_wr
);
  a_r3_no_clear_without_go: assert property (@(posedge clk) disable iff (rst)
    !go_q |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  a_r4_mask_self_clears: assert property (@(posedge clk) disable iff (rst)
    (go_q && mask_wr == 2'b00) |=> (mask_q == '0));

  a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flags_q & ~VALID_MASK) == '0) && ((mask_q & ~VALID_MASK) == '0));

  a_r5_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
    ((evt_pulse & VALID_MASK) != '0) |=>
      ((flags_q & $past(evt_pulse & VALID_MASK)) == $past(evt_pulse & VALID_MASK)));

  a_r7_irq_high: assert property (@(posedge clk) disable iff (rst)
    (flags_q != '0) |=> irq_out);

  a_r7_irq_low: assert property (@(posedge clk) disable iff (rst)
    (flags_q == '0) |=> !irq_out);

  a_r8_cause_implies_flag: assert property (@(posedge clk) disable iff (rst)
    (cause_q != 2'b00) |-> flags_q[OC_IDX]);

  a_r10_acm_forces_mode: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[ACM_IDX] |=> (mode_q == 4'd0));
endmodule

bind irq_stage_ctrl irq_stage_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_pulse(evt_pulse),
  .go_q     (go_q),
  .mask_q   (mask_q),
  .flags_q  (flags_q),
  .cause_q  (cause_q),
  .mode_q   (mode_q),
  .irq_out  (irq_out),
  .mask_wr  (mask_wr)
);

// File: tb/irq_stage_ctrl_test.sv
`timescale 1ns/1ps
module irq_stage_ctrl_test;
  localparam logic [15:0] VALID = 16'hDFFD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] evt_pulse = '0;
  logic        oc_div_evt = 1'b0, oc_main_evt = 1'b0;
  logic        mode_wr = 1'b0;
  logic [3:0]  mode_val = '0;
  logic        irq_out;

  int n_checks = 0, n_fail = 0;
  logic [15:0] model;
  logic [7:0]  d;

  always #2.5 clk = ~clk;

  irq_stage_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .oc_div_evt(oc_div_evt), .oc_main_evt(oc_main_evt),
    .mode_wr(mode_wr), .mode_val(mode_val), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] v);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic trig();
    wr(8'h04, 8'h20);
    @(negedge clk);
  endtask

  task automatic read_flags(output logic [15:0] f);
    logic [7:0] lo, hi;
    rd(8'h00, lo);
    rd(8'h01, hi);
    f = {hi, lo};
  endtask

  task automatic clear_all();
    wr(8'h02, 8'hFF); wr(8'h03, 8'hFF); trig();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    for (int a = 0; a < 7; a++) begin
      rd(8'(a), d);
      check("R1 reset read", {8'h0, d}, 16'h0);
    end
    check("R7 reset irq", {15'h0, irq_out}, 16'h0);

    // R1/R2 per-position sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] bit_i;
      bit_i = 16'h1 << i;
      pulse(bit_i);
      read_flags(f);
      check("R1 single flag", f, bit_i & VALID);
      check("R2 irq per flag", {15'h0, irq_out}, {15'h0, (bit_i & VALID) != 0});
      clear_all();
    end

    // R3/R4 staged clear sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] bit_i;
      bit_i = 16'h1 << i;
      pulse(16'hFFFF);
      wr(8'h02, bit_i[7:0]); wr(8'h03, bit_i[15:8]);
      @(negedge clk);
      read_flags(f);
      check("R3 mask write alone", f, VALID);
      rd(8'h02, d);
      check("R4 mask reads zero", {8'h0, d}, 16'h0);
      trig();
      read_flags(f);
      check("R4 triggered clear", f, VALID & ~bit_i);
      trig();
      read_flags(f);
      check("R4 mask self-cleared", f, VALID & ~bit_i);
      clear_all();
    end

    // R2 reserved mask bits ignored
    pulse(16'hFFFF);
    wr(8'h02, 8'h02); wr(8'h03, 8'h20); trig();
    read_flags(f);
    check("R2 reserved mask no clear", f, VALID);
    clear_all();

    // R5 event wins over clear
    pulse(16'h0081);
    wr(8'h02, 8'h81); wr(8'h03, 8'h00);
    wr(8'h04, 8'h20);
    evt_pulse = 16'h0080;
    @(negedge clk);
    evt_pulse = '0;
    read_flags(f);
    check("R5 event wins", f, 16'h0080);
    clear_all();

    // R6 zero-mask trigger
    pulse(16'h4400);
    trig();
    read_flags(f);
    check("R6 zero mask trigger", f, 16'h4400);
    clear_all();

    // R7 irq timing
    pulse(16'h0004);
    check("R7 irq lags set", {15'h0, irq_out}, 16'h0);
    @(negedge clk);
    check("R7 irq high", {15'h0, irq_out}, 16'h1);
    wr(8'h02, 8'h04);
    wr(8'h04, 8'h20);
    @(negedge clk);
    check("R7 irq lags clear", {15'h0, irq_out}, 16'h1);
    @(negedge clk);
    check("R7 irq low", {15'h0, irq_out}, 16'h0);

    // R8 over-current cause
    oc_div_evt = 1'b1; @(negedge clk); oc_div_evt = 1'b0;
    rd(8'h05, d);
    check("R8 divider cause", {8'h0, d}, 16'h0010);
    read_flags(f);
    check("R8 oc flag set", f, 16'h0008);
    oc_main_evt = 1'b1; @(negedge clk); oc_main_evt = 1'b0;
    rd(8'h05, d);
    check("R8 both causes", {8'h0, d}, 16'h0011);
    wr(8'h02, 8'h80); trig();
    rd(8'h05, d);
    check("R8 other clear keeps cause", {8'h0, d}, 16'h0011);
    wr(8'h02, 8'h08); trig();
    rd(8'h05, d);
    check("R8 cause cleared", {8'h0, d}, 16'h0);
    read_flags(f);
    check("R8 oc flag cleared", f, 16'h0);
    pulse(16'h0008);
    wr(8'h02, 8'h08); wr(8'h04, 8'h20);
    oc_main_evt = 1'b1; @(negedge clk); oc_main_evt = 1'b0;
    rd(8'h05, d);
    check("R8 cause kept when event wins", {8'h0, d}, 16'h0001);
    clear_all();

    // R9 mode encodings
    foreach (f[k]) begin
      mode_val = 4'(k); mode_wr = 1'b1; @(negedge clk); mode_wr = 1'b0;
      rd(8'h06, d);
      check("R9 mode load", {8'h0, d}, {12'h0, 4'(k)});
    end

    // R10 AC-missing forces mode
    mode_val = 4'b1001; mode_wr = 1'b1; @(negedge clk); mode_wr = 1'b0;
    pulse(16'h0400);
    rd(8'h06, d);
    check("R10 acm clears mode", {8'h0, d}, 16'h0);
    mode_val = 4'b1000; mode_wr = 1'b1; evt_pulse = 16'h0400;
    @(negedge clk);
    mode_wr = 1'b0; evt_pulse = '0;
    rd(8'h06, d);
    check("R10 acm beats load", {8'h0, d}, 16'h0);

    finish_run();
  end
endmodule